// File: doc/BRIEF.md
# Cause Register with Count-Stop and Software Interrupt Control

This block holds the cause register of one processor context, together with the side effects that software writes to it produce. A write strobe with 32-bit data updates the register through a fixed sparse write mask. Bits outside the mask keep their value. One writable bit stops a free-running count timer. Two others request software interrupts. A feature input widens the mask to include the count-stop bit, and only parts that implement the newer instruction-set revision drive it high.

Side effects come only from bits that actually change. When the count-stop bit flips to 1, the timer freezes. When it flips to 0, the timer resumes. When a software-interrupt pending bit flips, the matching request line is driven to its new value. A write that leaves those bits unchanged disturbs neither the timer nor the request lines.

Local writes and writes from another thread context use the same port. The block is therefore instanced once per context, and the issuing logic steers either kind of write to the target context's instance.

Top module: `cause_count_ctl`

## Requirements
- R1: After reset the register reads 0, `count_en` is 1, `count_val` is 0 and both `soft_irq` lines are 0.
- R2: On a cycle with `wr_en` high, bits 23:22 and bits 9:8 take the values of `wr_data` at those positions, visible on `rd_data` from the next cycle.
- R3: Bit 27 (count stop) is written from `wr_data[27]` only when `rev2_en` is high during the write. Otherwise it keeps its value.
- R4: Every bit other than 27, 23:22 and 9:8 keeps its value on a write, whatever `wr_data` holds. After reset these bits therefore always read 0.
- R5: `count_en` is the inverse of bit 27. It changes in the cycle after a write that flips that bit.
- R6: `count_val` rises by one on every clock edge where `count_en` was 1, and holds on every edge where it was 0. This includes the edge that carries the write.
- R7: `soft_irq[i]` (i = 0, 1) is set to the new value of register bit 8+i in the cycle after a write that changes that bit. A write that leaves the bit unchanged leaves the line unchanged.
- R8: With `wr_en` low the register does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rev2_en | input | 1 | Newer revision present; makes bit 27 writable |
| rd_data | output | 32 | Current register value |
| count_en | output | 1 | Count timer running |
| count_val | output | CNT_W | Count timer value |
| soft_irq | output | 2 | Software interrupt request lines |

## Verification
The write sweep covers every combination of the four sparsely writable bits. Each combination is tried against an all-zeros background and an all-ones background, with the count-stop bit set and clear, and with the revision input high and low. The two backgrounds show whether the mask leaks or drops bits. The revision input shows whether bit 27 is gated. Repeating a value shows whether side effects fire on writes that change nothing. Around each write the timer is compared with a count based on whether it was running before the write edge, which pins down the exact cycle of each stop and restart. Idle windows then confirm that a stopped timer holds and a running one advances.

// File: rtl/cause_count_ctl.sv
module cause_count_ctl #(
  parameter int CNT_W  = 32,
  parameter int DC_BIT = 27,
  parameter int SW_LO  = 8,
  parameter logic [31:0] BASE_MASK = 32'h00C00300
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic             rev2_en,
  output logic [31:0]      rd_data,
  output logic             count_en,
  output logic [CNT_W-1:0] count_val,
  output logic [1:0]       soft_irq
);
  localparam logic [31:0] DC_MASK = 32'd1 << DC_BIT;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [31:0]      cause_q, cause_d, wmask, flips;
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       swi_q;

  assign wmask   = BASE_MASK | (rev2_en ? DC_MASK : 32'd0);
  assign cause_d = wr_en ? ((cause_q & ~wmask) | (wr_data & wmask)) : cause_q;
  assign flips   = cause_q ^ cause_d;

  always_ff @(posedge clk) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             run_q <= 1'b1;
    else if (flips[DC_BIT]) run_q <= ~cause_d[DC_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (run_q) cnt_q <= cnt_q + CNT_ONE;
  end

  for (genvar i = 0; i < 2; i++) begin : g_swi
    always_ff @(posedge clk) begin
      if (!rst_n)                swi_q[i] <= 1'b0;
      else if (flips[SW_LO + i]) swi_q[i] <= cause_d[SW_LO + i];
    end
  end

  assign rd_data   = cause_q;
  assign count_en  = run_q;
  assign count_val = cnt_q;
  assign soft_irq  = swi_q;
endmodule

module cause_count_ctl_chk #(
  parameter int CNT_W  = 32,
  parameter int DC_BIT = 27,
  parameter int SW_LO  = 8,
  parameter logic [31:0] BASE_MASK = 32'h00C00300
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [31:0]      wr_data,
  input logic             rev2_en,
  input logic [31:0]      rd_data,
  input logic             count_en,
  input logic [CNT_W-1:0] count_val,
  input logic [1:0]       soft_irq
);
  localparam logic [31:0] ALL_MASK = BASE_MASK | (32'd1 << DC_BIT);

  p_masked_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_data & BASE_MASK) == ($past(wr_data) & BASE_MASK)));
  p_dc_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rev2_en) |=> $stable(rd_data[DC_BIT]));
  p_unmasked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rd_data & ~ALL_MASK) == ($past(rd_data) & ~ALL_MASK)));
  p_enable_inverse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count_en == !rd_data[DC_BIT]);
  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count_en |=> (count_val == $past(count_val) + CNT_W'(1)));
  p_count_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en |=> $stable(count_val));
  p_soft_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_irq == rd_data[SW_LO+1:SW_LO]);
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));
endmodule

bind cause_count_ctl cause_count_ctl_chk #(
  .CNT_W(CNT_W), .DC_BIT(DC_BIT), .SW_LO(SW_LO), .BASE_MASK(BASE_MASK)
) u_chk (.*);

// File: tb/cause_count_ctl_test.sv
module cause_count_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rev2_en = 1'b0;
  logic [31:0] rd_data;
  logic        count_en;
  logic [31:0] count_val;
  logic [1:0]  soft_irq;

  int vecs = 0;
  int errs = 0;
  logic [31:0] exp_reg = '0;

  always #5 clk = ~clk;

  cause_count_ctl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rev2_en(rev2_en), .rd_data(rd_data), .count_en(count_en),
    .count_val(count_val), .soft_irq(soft_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] d, input logic rv);
    logic [31:0] m, c0;
    logic        en0;
    m   = 32'h00C00300 | (rv ? 32'h08000000 : 32'h0);
    c0  = count_val;
    en0 = count_en;
    wr_en = 1'b1; wr_data = d; rev2_en = rv;
    @(negedge clk);
    wr_en = 1'b0; wr_data = ~d;
    exp_reg = (exp_reg & ~m) | (d & m);
    check("R2/R3/R4 register", rd_data, exp_reg);
    check("R5 count_en", {31'd0, count_en}, {31'd0, ~exp_reg[27]});
    check("R6 count at write edge", count_val, c0 + (en0 ? 32'd1 : 32'd0));
    check("R7 soft_irq", {30'd0, soft_irq}, {30'd0, exp_reg[9:8]});
  endtask

  task automatic idle_window(input int n);
    logic [31:0] c0, r0;
    c0 = count_val; r0 = rd_data;
    repeat (n) @(negedge clk);
    check("R8 idle hold", rd_data, r0);
    check("R6 count window", count_val, c0 + (count_en ? n : 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset reg", rd_data, 32'd0);
    check("R1 reset count_en", {31'd0, count_en}, 32'd1);
    check("R1 reset soft_irq", {30'd0, soft_irq}, 32'd0);
    check("R1 reset count", count_val, 32'd1);
    for (int rv = 0; rv < 2; rv++)
      for (int dc = 0; dc < 2; dc++)
        for (int k = 0; k < 16; k++) begin
          logic [31:0] d;
          d = (k[0] ^ dc[0]) ? 32'hFFFFFFFF : 32'h00000000;
          d[23:22] = k[3:2];
          d[9:8]   = k[1:0];
          d[27]    = dc[0];
          do_write(d, rv[0]);
          do_write(d, rv[0]);
          if (k % 4 == 3) idle_window(5);
        end
    do_write(32'h08000000, 1'b1);
    idle_window(7);
    do_write(32'h00000000, 1'b0);
    idle_window(4);
    do_write(32'h00000000, 1'b1);
    idle_window(6);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    vecs++; errs++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule